// File: doc/BRIEF.md
# Exception Recognition and Vectoring Unit

This block owns the core's 32-bit processor state word and decides, every cycle, whether a pending exception is accepted. Four event sources feed it: a machine-check line, an external interrupt line, a timer (decrementer) line and an instruction-completion strobe that drives single-step tracing. When an event is accepted, the block saves the current state word and the return address, builds the state word for the handler, and one cycle later presents a redirect to instruction fetch with the handler address.

The handler address is a fixed offset per cause added to one of two bases, and the base is chosen by a state bit. A return strobe puts back the saved state word and redirects fetch to the saved return address. A write port lets software load the state word. The privilege, endian and floating-point-enable bits are driven straight out to the rest of the core.

Top module: `exc_vector_unit`

## Requirements
- R1: While reset is held and after it is released, the state word equals the parameter RESET_STATE masked to its writable bits (default 0x0000_0040), `redirect_valid_o` is 0, and both saved registers read 0.
- R2: On exception entry, state bit 0 (little-endian mode) takes the value that state bit 16 (handler little-endian select) had before entry; 1 selects little-endian, 0 big-endian.
- R3: With state bit 15 (interrupt enable) clear, the external interrupt and timer lines are never taken and the state word is left unchanged; with it set, either can be taken.
- R4: With state bit 12 (machine-check enable) clear, the machine-check line is never taken; with it set, it is taken.
- R5: At most one exception is taken per cycle, in the fixed priority machine check, trace, external interrupt, timer. A trace that loses to a machine check in the same cycle is dropped.
- R6: On entry, `save_state_o` takes the old state word and `save_pc_o` takes `ret_addr_i`. In the new state word, bits 15, 14 (user mode), 13 (floating-point enable), 10 (single-step) and 9 (branch-trace enable) are 0. All other bits keep their value, except bit 0, which follows R2.
- R7: One cycle after a take, `redirect_valid_o` pulses for exactly one cycle. `redirect_pc_o` is the base plus the offset. The base is 0x0000_0000 when state bit 6 (high vector base) is 0 and 0xFFF0_0000 when it is 1. The offsets are 0x200 (machine check), 0xD00 (trace), 0x500 (external) and 0x900 (timer). `redirect_cause_o` is 0, 1, 2 or 3 in that same order.
- R8: Only bits 0, 1, 6, 8 to 16 are writable. Written values in every other position are dropped, and those positions always read 0.
- R9: A return strobe with no take in the same cycle loads the state word from `save_state_o` (masked as in R8). On the next cycle it pulses `redirect_valid_o` with `redirect_pc_o` equal to `save_pc_o`.
- R10: With state bit 10 set, an `insn_done_i` strobe with `insn_exc_i` low arms a trace, which is taken on the following cycle. A completion with `insn_exc_i` high arms nothing.
- R11: `user_mode_o`, `little_endian_o` and `fpu_enable_o` equal state bits 14, 0 and 13 at all times.
- R12: An exception take has precedence over a return strobe and over a software write in the same cycle. Those two are then discarded, and a return strobe has precedence over a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mchk_i | input | 1 | Machine-check request (level) |
| ext_irq_i | input | 1 | External interrupt request (level) |
| dec_irq_i | input | 1 | Timer request (level) |
| insn_done_i | input | 1 | An instruction completed this cycle |
| insn_exc_i | input | 1 | The completing instruction raised another exception |
| ret_addr_i | input | 32 | Return address saved on entry |
| rfi_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Software write of the state word |
| wr_data_i | input | 32 | Write data |
| state_o | output | 32 | Current state word |
| save_state_o | output | 32 | Saved state word |
| save_pc_o | output | 32 | Saved return address |
| redirect_valid_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect address |
| redirect_cause_o | output | 2 | Cause of the last take |
| user_mode_o | output | 1 | User-mode privilege bit |
| little_endian_o | output | 1 | Current endian mode |
| fpu_enable_o | output | 1 | Floating-point dispatch allowed |

## Verification
The assertions assume that request lines are levels that the source deasserts once the handler is entered, and that the return strobe is only raised when the saved registers hold a real context. The stimulus drives each request for exactly one cycle, and it issues a return strobe only after an entry has filled the saved registers. The sweep covers every combination of the three request lines, the two enables and the vector base bit. Directed sequences then cover trace arming, priority collisions and same-cycle conflicts between write, return and take.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int NUM_CAUSE = 4;
  localparam int CAUSE_W   = $clog2(NUM_CAUSE);

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_MCHK  = 2'd0,
    CAUSE_TRACE = 2'd1,
    CAUSE_EXT   = 2'd2,
    CAUSE_DEC   = 2'd3
  } cause_e;

  // state word bit positions (index 0 = least significant)
  localparam int B_LE      = 0;
  localparam int B_RECOV   = 1;
  localparam int B_VEC_HI  = 6;
  localparam int B_FPM1    = 8;
  localparam int B_BTRACE  = 9;
  localparam int B_STEP    = 10;
  localparam int B_FPM0    = 11;
  localparam int B_MCHK_EN = 12;
  localparam int B_FPU_EN  = 13;
  localparam int B_USER    = 14;
  localparam int B_IRQ_EN  = 15;
  localparam int B_HDL_LE  = 16;

  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  localparam logic [XLEN-1:0] WR_MASK =
      (ONE << B_LE) | (ONE << B_RECOV) | (ONE << B_VEC_HI) | (ONE << B_FPM1) |
      (ONE << B_BTRACE) | (ONE << B_STEP) | (ONE << B_FPM0) | (ONE << B_MCHK_EN) |
      (ONE << B_FPU_EN) | (ONE << B_USER) | (ONE << B_IRQ_EN) | (ONE << B_HDL_LE);

  localparam logic [XLEN-1:0] CLR_MASK =
      (ONE << B_IRQ_EN) | (ONE << B_USER) | (ONE << B_FPU_EN) |
      (ONE << B_STEP) | (ONE << B_BTRACE);

  localparam logic [XLEN-1:0] BASE_LO = '0;
  localparam logic [XLEN-1:0] BASE_HI = 32'hFFF0_0000;

  function automatic logic [XLEN-1:0] sanitize(logic [XLEN-1:0] v);
    return v & WR_MASK;
  endfunction

  function automatic logic [XLEN-1:0] entry_state(logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r       = v & ~CLR_MASK;
    r[B_LE] = v[B_HDL_LE];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] vec_offset(cause_e c);
    case (c)
      CAUSE_MCHK:  return XLEN'(12'h200);
      CAUSE_TRACE: return XLEN'(12'hD00);
      CAUSE_EXT:   return XLEN'(12'h500);
      default:     return XLEN'(12'h900);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] vector_addr(cause_e c, logic hi);
    return (hi ? BASE_HI : BASE_LO) + vec_offset(c);
  endfunction

  function automatic cause_e grant_to_cause(logic [NUM_CAUSE-1:0] g);
    cause_e c;
    c = CAUSE_MCHK;
    for (int k = 0; k < NUM_CAUSE; k++) begin
      if (g[k]) c = cause_e'(k[CAUSE_W-1:0]);
    end
    return c;
  endfunction
endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  for (genvar k = 0; k < N; k++) begin : g_pri
    if (k == 0) begin : g_top
      assign grant_o[k] = req_i[k];
    end else begin : g_rest
      assign grant_o[k] = req_i[k] & ~(|req_i[k-1:0]);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/exc_state_reg.sv
module exc_state_reg
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_STATE = 32'h0000_0040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            rfi_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic [XLEN-1:0] ret_addr_i,
  output logic [XLEN-1:0] state_o,
  output logic [XLEN-1:0] save_state_o,
  output logic [XLEN-1:0] save_pc_o
);
  logic [XLEN-1:0] state_q, save_state_q, save_pc_q;
  logic [XLEN-1:0] state_nxt;

  always_comb begin
    state_nxt = state_q;
    if (take_i)       state_nxt = entry_state(state_q);
    else if (rfi_i)   state_nxt = sanitize(save_state_q);
    else if (wr_en_i) state_nxt = sanitize(wr_data_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= sanitize(RESET_STATE);
      save_state_q <= '0;
      save_pc_q    <= '0;
    end else begin
      state_q <= state_nxt;
      if (take_i) begin
        save_state_q <= state_q;
        save_pc_q    <= ret_addr_i;
      end
    end
  end

  assign state_o      = state_q;
  assign save_state_o = save_state_q;
  assign save_pc_o    = save_pc_q;
endmodule

// File: rtl/exc_step_trace.sv
module exc_step_trace (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en_i,
  input  logic insn_done_i,
  input  logic insn_exc_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;
  logic arm_w;

  assign arm_w = step_en_i & insn_done_i & ~insn_exc_i & ~take_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (arm_w)  pend_q <= 1'b1;
    else if (take_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/exc_redirect.sv
module exc_redirect
  import exc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take_i,
  input  cause_e             cause_i,
  input  logic               vec_hi_i,
  input  logic               rfi_i,
  input  logic [XLEN-1:0]    save_pc_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               valid_q;
  logic [XLEN-1:0]    pc_q;
  logic [CAUSE_W-1:0] cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pc_q    <= '0;
      cause_q <= '0;
    end else if (take_i) begin
      valid_q <= 1'b1;
      pc_q    <= vector_addr(cause_i, vec_hi_i);
      cause_q <= cause_i;
    end else if (rfi_i) begin
      valid_q <= 1'b1;
      pc_q    <= save_pc_i;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign pc_o    = pc_q;
  assign cause_o = cause_q;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter logic [31:0] RESET_STATE = 32'h0000_0040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mchk_i,
  input  logic        ext_irq_i,
  input  logic        dec_irq_i,
  input  logic        insn_done_i,
  input  logic        insn_exc_i,
  input  logic [31:0] ret_addr_i,
  input  logic        rfi_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] state_o,
  output logic [31:0] save_state_o,
  output logic [31:0] save_pc_o,
  output logic        redirect_valid_o,
  output logic [31:0] redirect_pc_o,
  output logic [1:0]  redirect_cause_o,
  output logic        user_mode_o,
  output logic        little_endian_o,
  output logic        fpu_enable_o
);
  logic [XLEN-1:0]      state_q, save_state_q, save_pc_q;
  logic [NUM_CAUSE-1:0] req_w, grant_w;
  logic                 take_w;
  logic                 trace_pend_w;
  cause_e               cause_w;

  // request vector in priority order (index 0 wins)
  assign req_w[CAUSE_MCHK]  = mchk_i & state_q[B_MCHK_EN];
  assign req_w[CAUSE_TRACE] = trace_pend_w;
  assign req_w[CAUSE_EXT]   = ext_irq_i & state_q[B_IRQ_EN];
  assign req_w[CAUSE_DEC]   = dec_irq_i & state_q[B_IRQ_EN];

  exc_prio_arb #(.N(NUM_CAUSE)) u_arb (
    .req_i   (req_w),
    .grant_o (grant_w),
    .any_o   (take_w)
  );

  assign cause_w = grant_to_cause(grant_w);

  exc_state_reg #(.RESET_STATE(RESET_STATE)) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_w),
    .rfi_i        (rfi_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .ret_addr_i   (ret_addr_i),
    .state_o      (state_q),
    .save_state_o (save_state_q),
    .save_pc_o    (save_pc_q)
  );

  exc_step_trace u_trace (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en_i   (state_q[B_STEP]),
    .insn_done_i (insn_done_i),
    .insn_exc_i  (insn_exc_i),
    .take_i      (take_w),
    .pend_o      (trace_pend_w)
  );

  exc_redirect u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_w),
    .cause_i   (cause_w),
    .vec_hi_i  (state_q[B_VEC_HI]),
    .rfi_i     (rfi_i),
    .save_pc_i (save_pc_q),
    .valid_o   (redirect_valid_o),
    .pc_o      (redirect_pc_o),
    .cause_o   (redirect_cause_o)
  );

  assign state_o         = state_q;
  assign save_state_o    = save_state_q;
  assign save_pc_o       = save_pc_q;
  assign user_mode_o     = state_q[B_USER];
  assign little_endian_o = state_q[B_LE];
  assign fpu_enable_o    = state_q[B_FPU_EN];
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk
  import exc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ext_irq_i,
  input logic        dec_irq_i,
  input logic        rfi_i,
  input logic [31:0] ret_addr_i,
  input logic [31:0] state_q,
  input logic [31:0] save_state_q,
  input logic [31:0] save_pc_q,
  input logic [3:0]  grant_w,
  input logic        take_w,
  input logic        trace_pend_w,
  input logic        redirect_valid_o,
  input logic [31:0] redirect_pc_o
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w)); // R5

  AST_EXT_DEC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q[B_IRQ_EN] |-> !grant_w[CAUSE_EXT] && !grant_w[CAUSE_DEC]); // R3

  AST_MCHK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !state_q[B_MCHK_EN] |-> !grant_w[CAUSE_MCHK]); // R4

  AST_DEC_LOSES_TO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_w[CAUSE_DEC] |-> !(ext_irq_i && state_q[B_IRQ_EN]) && !trace_pend_w); // R5

  AST_ENTRY_ENDIAN: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> state_q[B_LE] == $past(state_q[B_HDL_LE])); // R2

  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> (state_q & CLR_MASK) == '0); // R6

  AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> save_state_q == $past(state_q) && save_pc_q == $past(ret_addr_i)); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & ~WR_MASK) == '0); // R8

  AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> redirect_valid_o &&
      redirect_pc_o[31:20] == ($past(state_q[B_VEC_HI]) ? 12'hFFF : 12'h000)); // R7

  AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rfi_i && !take_w |=> state_q == ($past(save_state_q) & WR_MASK) &&
      redirect_valid_o && redirect_pc_o == $past(save_pc_q)); // R9

  AST_TRACE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_pend_w) |-> $past(state_q[B_STEP])); // R10
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ext_irq_i        (ext_irq_i),
  .dec_irq_i        (dec_irq_i),
  .rfi_i            (rfi_i),
  .ret_addr_i       (ret_addr_i),
  .state_q          (state_q),
  .save_state_q     (save_state_q),
  .save_pc_q        (save_pc_q),
  .grant_w          (grant_w),
  .take_w           (take_w),
  .trace_pend_w     (trace_pend_w),
  .redirect_valid_o (redirect_valid_o),
  .redirect_pc_o    (redirect_pc_o)
);

// File: tb/exc_vector_unit_tb_top.sv
module exc_vector_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;

  // bit positions of the state word, as stated in the requirements
  localparam int P_LE = 0, P_VHI = 6, P_BT = 9, P_STEP = 10, P_MEN = 12;
  localparam int P_FPU = 13, P_USR = 14, P_IEN = 15, P_HLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mchk_i = 0, ext_irq_i = 0, dec_irq_i = 0, insn_done_i = 0, insn_exc_i = 0;
  logic rfi_i = 0, wr_en_i = 0;
  logic [31:0] ret_addr_i = '0, wr_data_i = '0;
  logic [31:0] state_o, save_state_o, save_pc_o, redirect_pc_o;
  logic redirect_valid_o, user_mode_o, little_endian_o, fpu_enable_o;
  logic [1:0] redirect_cause_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mchk_i(mchk_i), .ext_irq_i(ext_irq_i),
    .dec_irq_i(dec_irq_i), .insn_done_i(insn_done_i), .insn_exc_i(insn_exc_i),
    .ret_addr_i(ret_addr_i), .rfi_i(rfi_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .state_o(state_o), .save_state_o(save_state_o), .save_pc_o(save_pc_o),
    .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
    .redirect_cause_o(redirect_cause_o), .user_mode_o(user_mode_o),
    .little_endian_o(little_endian_o), .fpu_enable_o(fpu_enable_o)
  );

  function automatic logic [31:0] writable();
    logic [31:0] m = '0;
    int idx[12] = '{0, 1, 6, 8, 9, 10, 11, 12, 13, 14, 15, 16};
    foreach (idx[k]) m[idx[k]] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_entry(logic [31:0] old);
    logic [31:0] r = old;
    r[P_IEN] = 0; r[P_USR] = 0; r[P_FPU] = 0; r[P_STEP] = 0; r[P_BT] = 0;
    r[P_LE] = old[P_HLE];
    return r;
  endfunction

  function automatic logic [31:0] exp_vec(int cause, logic hi);
    logic [31:0] off [4] = '{32'h200, 32'hD00, 32'h500, 32'h900};
    return (hi ? 32'hFFF0_0000 : 32'h0) | off[cause];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic write_state(input logic [31:0] v);
    wr_en_i = 1; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  // drive requests for one cycle, return at the negedge after the take edge
  task automatic pulse(input logic mc, input logic ex, input logic dc, input logic [31:0] ra);
    mchk_i = mc; ext_irq_i = ex; dec_irq_i = dc; ret_addr_i = ra;
    @(negedge clk);
    mchk_i = 0; ext_irq_i = 0; dec_irq_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] mask, old, v, ra;
    mask = writable();
    repeat (3) @(negedge clk);
    chk("R1 state in reset", state_o, 32'h40);
    rst_n = 1;
    @(negedge clk);
    chk("R1 state after reset", state_o, 32'h40);
    chk("R1 redirect idle", {31'b0, redirect_valid_o}, 32'h0);
    chk("R1 save_state", save_state_o, 32'h0);
    chk("R1 save_pc", save_pc_o, 32'h0);

    // sweep: enables, base bit and the three request lines
    for (int i = 0; i < 64; i++) begin
      logic ie, me, hi, mc, ex, dc;
      int cause;
      ie = i[0]; me = i[1]; hi = i[2]; mc = i[3]; ex = i[4]; dc = i[5];
      v = 32'hFFFF_FFFF;
      v[P_IEN] = ie; v[P_MEN] = me; v[P_VHI] = hi; v[P_STEP] = 0;
      v[P_HLE] = i[1] ^ i[2]; v[P_LE] = ~(i[1] ^ i[2]); v[P_USR] = i[0] ^ i[3];
      v[P_FPU] = i[4];
      write_state(v);
      old = v & mask;
      chk("R8 reserved dropped", state_o, old);
      chk("R11 status outputs", {29'b0, user_mode_o, little_endian_o, fpu_enable_o},
          {29'b0, old[P_USR], old[P_LE], old[P_FPU]});
      cause = (mc && me) ? 0 : (ex && ie) ? 2 : (dc && ie) ? 3 : -1;
      ra = 32'h4000 + 32'(i * 8);
      pulse(mc, ex, dc, ra);
      if (cause < 0) begin
        chk("R3/R4 no take", {31'b0, redirect_valid_o}, 32'h0);
        chk("R3 state kept", state_o, old);
      end else begin
        chk("R7 redirect valid", {31'b0, redirect_valid_o}, 32'h1);
        chk("R7 vector", redirect_pc_o, exp_vec(cause, hi));
        chk("R5 cause", {30'b0, redirect_cause_o}, 32'(cause));
        chk("R2/R6 entry state", state_o, exp_entry(old));
        chk("R6 save_state", save_state_o, old);
        chk("R6 save_pc", save_pc_o, ra);
        @(negedge clk);
        chk("R7 one-cycle pulse", {31'b0, redirect_valid_o}, 32'h0);
      end
    end

    // R10: completion with another exception arms nothing
    v = mask; v[P_IEN] = 0; v[P_STEP] = 1; v[P_VHI] = 0;
    write_state(v);
    insn_done_i = 1; insn_exc_i = 1;
    @(negedge clk);
    insn_done_i = 0; insn_exc_i = 0;
    @(negedge clk);
    chk("R10 no trace after faulting insn", {31'b0, redirect_valid_o}, 32'h0);
    @(negedge clk);
    chk("R10 still no trace", {31'b0, redirect_valid_o}, 32'h0);

    // R10: clean completion raises trace one cycle later
    insn_done_i = 1; ret_addr_i = 32'h7700;
    @(negedge clk);
    insn_done_i = 0;
    chk("R10 trace not yet", {31'b0, redirect_valid_o}, 32'h0);
    @(negedge clk);
    chk("R10 trace taken", {31'b0, redirect_valid_o}, 32'h1);
    chk("R10 trace vector", redirect_pc_o, 32'h0000_0D00);
    chk("R10 trace cause", {30'b0, redirect_cause_o}, 32'h1);
    chk("R6 step cleared", {31'b0, state_o[P_STEP]}, 32'h0);

    // R5: trace beats external; external then masked by entry
    v = mask; v[P_IEN] = 1; v[P_STEP] = 1; v[P_VHI] = 1; v[P_MEN] = 0;
    write_state(v);
    insn_done_i = 1;
    @(negedge clk);
    insn_done_i = 0; ext_irq_i = 1;
    @(negedge clk);
    chk("R5 trace over external", {30'b0, redirect_cause_o}, 32'h1);
    chk("R5 trace vector high base", redirect_pc_o, 32'hFFF0_0D00);
    @(negedge clk);
    chk("R3 external held after entry", {31'b0, redirect_valid_o}, 32'h0);
    ext_irq_i = 0;

    // R5: machine check beats armed trace and the trace is dropped
    v = mask; v[P_IEN] = 0; v[P_STEP] = 1; v[P_MEN] = 1; v[P_VHI] = 0;
    write_state(v);
    insn_done_i = 1;
    @(negedge clk);
    insn_done_i = 0; mchk_i = 1;
    @(negedge clk);
    mchk_i = 0;
    chk("R5 machine check over trace", {30'b0, redirect_cause_o}, 32'h0);
    @(negedge clk);
    chk("R5 dropped trace", {31'b0, redirect_valid_o}, 32'h0);

    // R9: return restores state and redirects to saved address
    v = mask; v[P_IEN] = 1; v[P_USR] = 1; v[P_HLE] = 1; v[P_LE] = 0; v[P_STEP] = 0;
    write_state(v);
    old = v & mask;
    pulse(0, 1, 0, 32'h0000_ABC0);
    chk("R2 handler little-endian", {31'b0, little_endian_o}, 32'h1);
    rfi_i = 1;
    @(negedge clk);
    rfi_i = 0;
    chk("R9 state restored", state_o, old);
    chk("R9 return redirect", {31'b0, redirect_valid_o}, 32'h1);
    chk("R9 return address", redirect_pc_o, 32'h0000_ABC0);
    chk("R11 user mode back", {31'b0, user_mode_o}, 32'h1);

    // R12: take beats a write and a return in the same cycle
    wr_en_i = 1; wr_data_i = 32'h0; rfi_i = 1;
    pulse(0, 1, 0, 32'h0000_5550);
    wr_en_i = 0; rfi_i = 0;
    chk("R12 take wins", state_o, exp_entry(old));
    chk("R12 save_pc from take", save_pc_o, 32'h0000_5550);
    chk("R12 cause external", {30'b0, redirect_cause_o}, 32'h2);
    // R12: return beats a write
    v = 32'h0000_0040;
    wr_en_i = 1; wr_data_i = v; rfi_i = 1;
    @(negedge clk);
    wr_en_i = 0; rfi_i = 0;
    chk("R12 return over write", state_o, old);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule